// File: doc/BRIEF.md
# Nine-bit serial panel register writer

This block issues register writes to a display controller across a write-only three-wire serial link made of chip select, serial clock and serial data. Every word on the wire is nine bits long. Its top bit tells the panel whether the remaining eight bits are a command or a data byte.

A client offers one request at a time. A request holds an 8-bit register address, a length code that selects zero, one or two payload bytes, and a 16-bit payload. The block sends the whole frame inside a single chip-select burst. It then holds chip select high for one serial clock period and gives a one-cycle completion pulse. Each half period of the serial clock lasts a programmable number of system clock cycles, so the divisor is always even.

Top module: `spi9_reg_writer`

## Requirements
- R1: Each word is 9 bits and is shifted out most significant bit first. Bit 8 of a word is 0 for a command and 1 for data. The low 8 bits of a word carry the byte.
- R2: The first word of every frame is a command word, and its byte is `req_addr`.
- R3: Length code 0 sends 1 word, code 1 sends 2 words and code 2 sends 3 words. Code 3 is treated as code 2.
- R4: With code 1 the data word carries `req_data[7:0]`. With code 2 the first data word carries `req_data[15:8]` and the second carries `req_data[7:0]`.
- R5: Address 0x00 with length code 0 is sent as a lone command word with byte 0x00, and it completes like any other frame.
- R6: `cs_n` falls on the cycle a request is accepted. It stays low until the serial clock falls after the last bit, and it rises exactly once per frame.
- R7: `sclk` is low whenever `cs_n` is high. While `cs_n` is low, `sdo` changes only when `sclk` falls or when `cs_n` falls.
- R8: Each `sclk` half period lasts H system cycles. H is `half_div` sampled at acceptance, and a value of 0 acts as 1. The first rising edge of `sclk` comes H cycles after acceptance.
- R9: A request is accepted only while `busy` is low. A request offered while `busy` is high has no effect.
- R10: `done` is high for exactly one cycle. It comes 2H cycles after `cs_n` rises, which is 2H·(N+1) cycles after acceptance for an N-bit frame. `busy` drops in the same cycle.
- R11: After reset, `cs_n` is 1 and `sclk`, `busy` and `done` are 0.
- R12: Between back-to-back frames, `cs_n` stays high for at least 2H cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered this cycle |
| req_addr | input | 8 | Register address for the command word |
| req_len | input | 2 | Payload length code (0, 1, 2; 3 acts as 2) |
| req_data | input | 16 | Payload; the high byte is sent first for code 2 |
| half_div | input | DIV_W | System cycles per serial clock half period |
| busy | output | 1 | Frame or trailing gap in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |

## Verification
The accept edge serves as cycle zero for all timing, and that edge is marked by `busy` rising. The first `sclk` rise is due H cycles later. Each bit is captured on an `sclk` rise, and `done` must appear exactly 2H·(N+1) cycles after acceptance. The bench samples every output on the falling system clock edge, half a cycle after the registers settle. It measures these distances with a free-running cycle counter, so every check compares a counted interval against the figure computed from H and the length code.

// File: rtl/spi9_reg_writer.sv
module spi9_reg_writer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [7:0]       req_addr,
  input  logic [1:0]       req_len,
  input  logic [15:0]      req_data,
  input  logic [DIV_W-1:0] half_div,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  output logic             sclk,
  output logic             sdo
);
  localparam int FRAME_W = 27;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t              st;
  logic [FRAME_W-1:0] sreg;
  logic [DIV_W-1:0] hdiv, dcnt;
  logic [CNT_W-1:0] bits_left;
  logic             gap_ph;

  wire [1:0]       len_c   = (req_len == 2'd3) ? 2'd2 : req_len;
  wire [DIV_W-1:0] hdiv_in = (half_div == '0) ? DIV_W'(1) : half_div;
  wire             tick    = (dcnt == hdiv - DIV_W'(1));
  wire [CNT_W-1:0] nbits   = CNT_W'(9) * (CNT_W'(len_c) + CNT_W'(1));

  logic [FRAME_W-1:0] frame;
  always_comb begin
    case (len_c)
      2'd0:    frame = {1'b0, req_addr, 18'd0};
      2'd1:    frame = {1'b0, req_addr, 1'b1, req_data[7:0], 9'd0};
      default: frame = {1'b0, req_addr, 1'b1, req_data[15:8], 1'b1, req_data[7:0]};
    endcase
  end

  assign busy = (st != S_IDLE);
  assign sdo  = sreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sreg      <= '0;
      hdiv      <= DIV_W'(1);
      dcnt      <= '0;
      bits_left <= '0;
      gap_ph    <= 1'b0;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          sreg      <= frame;
          hdiv      <= hdiv_in;
          dcnt      <= '0;
          bits_left <= nbits;
          cs_n      <= 1'b0;
          st        <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          dcnt <= '0;
          if (!sclk) sclk <= 1'b1;
          else begin
            sclk <= 1'b0;
            if (bits_left == CNT_W'(1)) begin
              cs_n   <= 1'b1;
              gap_ph <= 1'b0;
              st     <= S_GAP;
            end else begin
              sreg      <= sreg << 1;
              bits_left <= bits_left - CNT_W'(1);
            end
          end
        end else dcnt <= dcnt + DIV_W'(1);
        S_GAP: if (tick) begin
          dcnt <= '0;
          if (!gap_ph) gap_ph <= 1'b1;
          else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end else dcnt <= dcnt + DIV_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi9_reg_writer_chk.sv
module spi9_reg_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic sdo
);
  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_sdo_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sdo != $past(sdo)) |-> ($fell(sclk) || $fell(cs_n)));

  p_cs_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $rose(busy));

  p_cs_within_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind spi9_reg_writer spi9_reg_writer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .cs_n(cs_n), .sclk(sclk), .sdo(sdo)
);

// File: tb/spi9_reg_writer_tb_top.sv
module spi9_reg_writer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_addr = '0;
  logic [1:0] req_len = '0;
  logic [15:0] req_data = '0;
  logic [7:0] half_div = 8'd1;
  logic busy, done, cs_n, sclk, sdo;

  always #2.5 clk = ~clk;

  spi9_reg_writer #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_data(req_data), .half_div(half_div),
    .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .sdo(sdo)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, acc_cyc = 0, done_cyc = 0, rise1_cyc = 0, cs_rise_cyc = 0;
  int done_cnt = 0, cs_rises = 0, sclk_bad = 0, cap_n = 0, last_gap = 0;
  logic [26:0] cap = '0;
  logic p_sclk = 1'b0, p_busy = 1'b0, p_cs = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (busy && !p_busy) begin
      acc_cyc = cyc; cap = '0; cap_n = 0; cs_rises = 0; rise1_cyc = 0;
    end
    if (sclk && !p_sclk && !cs_n) begin
      cap = {cap[25:0], sdo}; cap_n++;
      if (rise1_cyc == 0) rise1_cyc = cyc;
    end
    if (cs_n && sclk) sclk_bad++;
    if (cs_n && !p_cs) begin cs_rises++; cs_rise_cyc = cyc; end
    if (!cs_n && p_cs && cs_rise_cyc != 0) last_gap = cyc - cs_rise_cyc;
    if (done) begin done_cnt++; done_cyc = cyc; end
    p_sclk = sclk; p_busy = busy; p_cs = cs_n;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [26:0] exp_bits(input logic [1:0] len, input logic [7:0] a,
                                           input logic [15:0] d);
    case (len)
      2'd0:    return {18'd0, 1'b0, a};
      2'd1:    return {9'd0, 1'b0, a, 1'b1, d[7:0]};
      default: return {1'b0, a, 1'b1, d[15:8], 1'b1, d[7:0]};
    endcase
  endfunction

  task automatic wait_done(input int prev);
    for (int i = 0; i < 4000 && done_cnt == prev; i++) begin @(negedge clk); #1; end
  endtask

  task automatic run_frame(input logic [3:0] h, input logic [1:0] len,
                           input logic [7:0] a, input logic [15:0] d, input bit poke);
    int prev, hh, nw, nb;
    logic [1:0] lc;
    lc = (len == 2'd3) ? 2'd2 : len;
    hh = (h == 0) ? 1 : int'(h);
    nw = int'(lc) + 1; nb = 9 * nw;
    prev = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_len = len; req_addr = a; req_data = d; half_div = {4'd0, h};
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      for (int i = 0; i < 6; i++) @(negedge clk);
      req_valid = 1'b1; req_addr = 8'h55; req_len = 2'd2; req_data = 16'hA5C3; half_div = 8'd7;
      for (int i = 0; i < 10; i++) @(negedge clk);
      req_valid = 1'b0;
    end
    wait_done(prev);
    #1;
    chk(done_cnt == prev + 1, "R10 done count", done_cnt - prev, 1);
    chk(cap_n == nb, "R3 bit count", cap_n, nb);
    chk(cap == exp_bits(lc, a, d), (lc == 2) ? "R4 frame bits" : "R1 R2 frame bits",
        int'(cap), int'(exp_bits(lc, a, d)));
    chk(cs_rises == 1, "R6 cs bursts", cs_rises, 1);
    chk(rise1_cyc - acc_cyc == hh, "R8 first sclk rise", rise1_cyc - acc_cyc, hh);
    chk(done_cyc - acc_cyc == 2 * hh * (nb + 1), "R10 done latency",
        done_cyc - acc_cyc, 2 * hh * (nb + 1));
    chk(done_cyc - cs_rise_cyc == 2 * hh, "R10 gap before done", done_cyc - cs_rise_cyc, 2 * hh);
    chk(sclk_bad == 0, "R7 sclk idle", sclk_bad, 0);
    if (poke) begin
      for (int i = 0; i < 200; i++) @(negedge clk);
      #1;
      chk(!busy && done_cnt == prev + 1, "R9 ignored while busy", done_cnt - prev, 1);
    end
  endtask

  localparam logic [29:0] VEC [7] = '{
    {4'd1, 2'd0, 8'h00, 16'h0000},
    {4'd2, 2'd1, 8'hB0, 16'h0017},
    {4'd1, 2'd2, 8'hB8, 16'hFFF9},
    {4'd3, 2'd2, 8'hC3, 16'h2040},
    {4'd2, 2'd1, 8'h3A, 16'h1260},
    {4'd1, 2'd0, 8'h29, 16'hFFFF},
    {4'd4, 2'd2, 8'hEC, 16'h01F0}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0,
        "R11 reset state", {cs_n, sclk, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[i]) run_frame(VEC[i][29:26], VEC[i][25:24], VEC[i][23:16], VEC[i][15:0], 1'b0);

    run_frame(4'd1, 2'd0, 8'h00, 16'h1234, 1'b0);
    chk(cap == 27'h0, "R5 nop frame", int'(cap), 0);
    run_frame(4'd2, 2'd3, 8'hD3, 16'h0D0E, 1'b0);
    run_frame(4'd0, 2'd1, 8'hBD, 16'h0004, 1'b0);
    run_frame(4'd2, 2'd2, 8'hD4, 16'h11A4, 1'b1);

    begin
      int prev;
      prev = done_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_len = 2'd1; req_addr = 8'hCF; req_data = 16'h0002; half_div = 8'd3;
      wait_done(prev);
      wait_done(prev + 1);
      req_valid = 1'b0;
      for (int i = 0; i < 4; i++) @(negedge clk);
      #1;
      chk(done_cnt == prev + 2, "R12 back-to-back frames", done_cnt - prev, 2);
      chk(last_gap >= 6, "R12 cs high gap", last_gap, 6);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule